// File: doc/BRIEF.md
# Pulse-to-Counter Time Correlator

Once per second an external time reference gives a pulse on a discrete line. This block ties that pulse to a local tick counter that runs freely on the 20 MHz instrument clock. On every pulse it does three things. It captures the counter value and measures how many ticks passed since the previous pulse. It then waits a bounded time for the message word that carries the external time stamp of that pulse. When the stamp arrives in time, the block reports the pair (captured ticks, external stamp) as one correlation point. Software can then map external time onto the local counter.

The message input carries several kinds of word, and only the time kind takes part in correlation. The block flags three problems:
- a pulse period that strays from nominal by more than a tolerance set at an input;
- a pulse that never comes (sticky flag);
- a time message that cannot be paired (saturating count).

The pairing logic is a two-state machine:
- `PAIR_IDLE` means no pulse is waiting for its stamp.
- `PAIR_WAIT` means a captured pulse is waiting for its stamp.

Its transitions are:
- arm: IDLE to WAIT on a pulse.
- rearm: WAIT to WAIT on a new pulse, which restarts the window.
- match: WAIT to IDLE when a time message arrives.
- expire: WAIT to IDLE when the window runs out.

Top module: `pps_time_correlator`

## Requirements
- R1: While reset is asserted, every output is zero.
- R2: The local counter is 0 on the first clock edge after reset and rises by one on each edge. A rising edge of `pps_in` first sampled at edge k is captured at edge k+2. From then `latched_ticks` holds the value the counter had at edge k+2, that is, the number of edges since reset minus one.
- R3: From the second captured pulse on, `ticks_per_sec` equals the difference of the last two captured values, and `tps_valid` is 1.
- R4: At each capture with a previous capture present, `period_err` is set to 1 when |interval − NOMINAL| > `tol` and to 0 otherwise. It is 0 after the first capture.
- R5: A time message (`msg_kind` = 1) accepted on one of the WINDOW edges after the capture edge is paired. `paired_time` takes `msg_data` on that edge, and `corr_valid` is set to the inverse of `period_err`.
- R6: Every capture edge clears `corr_valid`. A pairing made while `period_err` is 1 leaves `corr_valid` at 0.
- R7: A time message with no pending pulse, or one arriving after the window, leaves `paired_time` unchanged and raises `orphan_count` by one, saturating at its maximum.
- R8: Messages with `msg_kind` other than 1 (0 attitude, 2 ancillary, 3 spare) change neither `paired_time`, `corr_valid` nor `orphan_count`.
- R9: When MISS_LIMIT edges pass after the last capture (or after reset) without a new capture, `missed_pulse` goes to 1 and stays there until reset. The counter keeps running, so the next interval spans the gap.
- R10: After a pairing, a further time message in the same second counts as an orphan and does not replace `paired_time`.
- R11: A time message on the same edge as a capture is counted as an orphan and is not paired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | instrument clock |
| rst_n | input | 1 | active-low asynchronous reset |
| pps_in | input | 1 | asynchronous once-per-second pulse |
| tol | input | CNT_W | allowed deviation of the period, in ticks |
| msg_valid | input | 1 | message word strobe |
| msg_kind | input | 2 | message kind; 1 = time |
| msg_data | input | TS_W | external time stamp |
| latched_ticks | output | CNT_W | counter value at the last capture |
| ticks_per_sec | output | CNT_W | ticks between the last two captures |
| tps_valid | output | 1 | ticks_per_sec is meaningful |
| period_err | output | 1 | last interval outside tolerance |
| paired_time | output | TS_W | stamp paired with latched_ticks |
| corr_valid | output | 1 | latched_ticks and paired_time form a valid pair |
| missed_pulse | output | 1 | sticky: a pulse was missed |
| orphan_count | output | ORPH_W | saturating count of unpaired time messages |

## Verification
A pulse edge first sampled at clock edge k appears in `latched_ticks`, `ticks_per_sec`, `tps_valid` and `period_err` after edge k+2, and `corr_valid` falls on that same edge. A message sampled at edge m shows in `paired_time`, `corr_valid` or `orphan_count` right after edge m. The reference model in the bench steps once per rising edge using the sampled inputs, and every output is compared with it on the following falling edge. Directed checks follow the same timing: each message or pulse is driven on a falling edge, and the result is read on the falling edge after the edge that consumes it.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic {
        PAIR_IDLE = 1'b0,
        PAIR_WAIT = 1'b1
    } pair_state_t;

    localparam logic [1:0] KIND_ATTITUDE  = 2'd0;
    localparam logic [1:0] KIND_TIME      = 2'd1;
    localparam logic [1:0] KIND_ANCILLARY = 2'd2;

endpackage

// File: rtl/ptc_sync.sv
module ptc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // a one-cycle strobe can never repeat on the next edge
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/ptc_timebase.sv
module ptc_timebase #(
    parameter int CNT_W      = 32,
    parameter int NOMINAL    = 20000000,
    parameter int MISS_LIMIT = 30000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic [CNT_W-1:0] tol,
    output logic [CNT_W-1:0] latched,
    output logic [CNT_W-1:0] interval,
    output logic             interval_valid,
    output logic             period_err,
    output logic             missed
);
    localparam int               MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0] NOM_V  = CNT_W'(NOMINAL);
    localparam logic [MISS_W-1:0] MISS_V = MISS_W'(MISS_LIMIT);

    logic [CNT_W-1:0]  tick_cnt;
    logic [MISS_W-1:0] since_cnt;
    logic              have_prev;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  deviation;
    logic              off_nominal;

    always_comb begin
        span        = tick_cnt - latched;
        deviation   = (span >= NOM_V) ? (span - NOM_V) : (NOM_V - span);
        off_nominal = deviation > tol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_cnt <= '0;
        else        tick_cnt <= tick_cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched        <= '0;
            interval       <= '0;
            interval_valid <= 1'b0;
            period_err     <= 1'b0;
            have_prev      <= 1'b0;
        end else if (pulse) begin
            latched   <= tick_cnt;
            have_prev <= 1'b1;
            if (have_prev) begin
                interval       <= span;
                interval_valid <= 1'b1;
                period_err     <= off_nominal;
            end else begin
                period_err     <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_cnt <= '0;
            missed    <= 1'b0;
        end else if (pulse) begin
            since_cnt <= '0;
        end else if (since_cnt != MISS_V) begin
            since_cnt <= since_cnt + MISS_W'(1);
            if (since_cnt == MISS_V - MISS_W'(1)) missed <= 1'b1;
        end
    end

    assert_missed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        missed |=> missed);

    assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |=> ($stable(latched) && $stable(interval) && $stable(period_err)));

    assert_tps_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        interval_valid |=> interval_valid);

endmodule

// File: rtl/ptc_pair.sv
module ptc_pair
    import ptc_pkg::*;
#(
    parameter int TS_W   = 32,
    parameter int ORPH_W = 8,
    parameter int WINDOW = 10000000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pulse,
    input  logic            msg_valid,
    input  logic [1:0]      msg_kind,
    input  logic [TS_W-1:0] msg_data,
    input  logic            period_err,
    output logic [TS_W-1:0] paired_time,
    output logic            corr_valid,
    output logic [ORPH_W-1:0] orphan_count
);
    localparam int                WIN_W    = $clog2(WINDOW + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WINDOW - 1);
    localparam logic [ORPH_W-1:0] ORPH_MAX = '1;

    pair_state_t      state, state_nx;
    logic [WIN_W-1:0] win_cnt;
    logic             is_time;
    logic             do_match;
    logic             orphan_hit;

    assign is_time    = msg_valid && (msg_kind == KIND_TIME);
    assign do_match   = (state == PAIR_WAIT) && is_time && !pulse;
    assign orphan_hit = is_time && (pulse || (state == PAIR_IDLE));

    always_comb begin
        state_nx = state;
        unique case (state)
            PAIR_IDLE: if (pulse) state_nx = PAIR_WAIT;
            PAIR_WAIT: begin
                if (pulse)                  state_nx = PAIR_WAIT;
                else if (is_time)           state_nx = PAIR_IDLE;
                else if (win_cnt == WIN_LAST) state_nx = PAIR_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PAIR_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt      <= '0;
            paired_time  <= '0;
            corr_valid   <= 1'b0;
            orphan_count <= '0;
        end else begin
            if (pulse)                    win_cnt <= '0;
            else if (state == PAIR_WAIT)  win_cnt <= win_cnt + WIN_W'(1);

            if (pulse) begin
                corr_valid <= 1'b0;
            end else if (do_match) begin
                paired_time <= msg_data;
                corr_valid  <= !period_err;
            end

            if (orphan_hit && orphan_count != ORPH_MAX)
                orphan_count <= orphan_count + ORPH_W'(1);
        end
    end

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PAIR_WAIT) |-> (win_cnt < WIN_W'(WINDOW)));

    assert_pulse_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !corr_valid);

    assert_valid_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> !period_err);

    assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PAIR_IDLE) || pulse) |=> $stable(paired_time));

    assert_orphan_never_falls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (orphan_count >= $past(orphan_count)));

    assert_other_kinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid || msg_kind != KIND_TIME) |=> $stable(orphan_count));

endmodule

// File: rtl/pps_time_correlator.sv
module pps_time_correlator #(
    parameter int CNT_W       = 32,
    parameter int TS_W        = 32,
    parameter int ORPH_W      = 8,
    parameter int NOMINAL     = 20000000,
    parameter int WINDOW      = 10000000,
    parameter int MISS_LIMIT  = 30000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_in,
    input  logic [CNT_W-1:0]  tol,
    input  logic              msg_valid,
    input  logic [1:0]        msg_kind,
    input  logic [TS_W-1:0]   msg_data,
    output logic [CNT_W-1:0]  latched_ticks,
    output logic [CNT_W-1:0]  ticks_per_sec,
    output logic              tps_valid,
    output logic              period_err,
    output logic [TS_W-1:0]   paired_time,
    output logic              corr_valid,
    output logic              missed_pulse,
    output logic [ORPH_W-1:0] orphan_count
);
    logic pulse;

    ptc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pps_in),
        .rise     (pulse)
    );

    ptc_timebase #(
        .CNT_W      (CNT_W),
        .NOMINAL    (NOMINAL),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_timebase (
        .clk            (clk),
        .rst_n          (rst_n),
        .pulse          (pulse),
        .tol            (tol),
        .latched        (latched_ticks),
        .interval       (ticks_per_sec),
        .interval_valid (tps_valid),
        .period_err     (period_err),
        .missed         (missed_pulse)
    );

    ptc_pair #(
        .TS_W   (TS_W),
        .ORPH_W (ORPH_W),
        .WINDOW (WINDOW)
    ) u_pair (
        .clk          (clk),
        .rst_n        (rst_n),
        .pulse        (pulse),
        .msg_valid    (msg_valid),
        .msg_kind     (msg_kind),
        .msg_data     (msg_data),
        .period_err   (period_err),
        .paired_time  (paired_time),
        .corr_valid   (corr_valid),
        .orphan_count (orphan_count)
    );

endmodule

// File: tb/pps_time_correlator_tb.sv
module pps_time_correlator_tb;
    localparam int NOM = 1000;
    localparam int WIN = 500;
    localparam int MISS = 1500;
    localparam int TOLV = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pps_in = 1'b0;
    logic [31:0] tol = 32'(TOLV);
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_kind = 2'd0;
    logic [31:0] msg_data = '0;
    logic [31:0] latched_ticks, ticks_per_sec, paired_time;
    logic        tps_valid, period_err, corr_valid, missed_pulse;
    logic [7:0]  orphan_count;

    int checks = 0;
    int errors = 0;
    longint ncyc = 0;

    pps_time_correlator #(
        .NOMINAL(NOM), .WINDOW(WIN), .MISS_LIMIT(MISS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .tol(tol),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_data(msg_data),
        .latched_ticks(latched_ticks), .ticks_per_sec(ticks_per_sec),
        .tps_valid(tps_valid), .period_err(period_err),
        .paired_time(paired_time), .corr_valid(corr_valid),
        .missed_pulse(missed_pulse), .orphan_count(orphan_count)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    longint m_cnt, m_latch, m_tps, m_paired, m_orph, m_since, m_win;
    bit     m_tpsv, m_perr, m_cv, m_miss, m_pend, m_prev;
    bit     h1, h2, h3;

    always @(posedge clk) begin
        ncyc++;
        if (!rst_n) begin
            m_cnt = 0; m_latch = 0; m_tps = 0; m_paired = 0; m_orph = 0;
            m_since = 0; m_win = 0; m_tpsv = 0; m_perr = 0; m_cv = 0;
            m_miss = 0; m_pend = 0; m_prev = 0; h1 = 0; h2 = 0; h3 = 0;
        end else begin
            bit pulse_now, tmsg;
            longint dev;
            pulse_now = h2 && !h3;
            tmsg = msg_valid && (msg_kind == 2'd1);
            if (pulse_now) begin
                if (m_prev) begin
                    m_tps = m_cnt - m_latch;
                    m_tpsv = 1;
                    dev = m_tps - NOM;
                    if (dev < 0) dev = -dev;
                    m_perr = (dev > TOLV);
                end else m_perr = 0;
                m_latch = m_cnt; m_prev = 1; m_pend = 1; m_win = 0;
                m_cv = 0; m_since = 0;
                if (tmsg && m_orph < 255) m_orph++;
            end else begin
                if (m_since < MISS) begin
                    m_since++;
                    if (m_since == MISS) m_miss = 1;
                end
                if (m_pend && tmsg) begin
                    m_paired = msg_data; m_cv = !m_perr; m_pend = 0;
                end else if (tmsg) begin
                    if (m_orph < 255) m_orph++;
                end else if (m_pend) begin
                    if (m_win == WIN - 1) m_pend = 0;
                    else m_win++;
                end
            end
            h3 = h2; h2 = h1; h1 = pps_in;
            m_cnt++;
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, ncyc);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 latched_ticks", latched_ticks, m_latch);
            chk("R3 ticks_per_sec", ticks_per_sec, m_tps);
            chk("R3 tps_valid", tps_valid, m_tpsv);
            chk("R4 period_err", period_err, m_perr);
            chk("R5 paired_time", paired_time, m_paired);
            chk("R6 corr_valid", corr_valid, m_cv);
            chk("R7 orphan_count", orphan_count, m_orph);
            chk("R9 missed_pulse", missed_pulse, m_miss);
        end
    end

    task automatic wait_until(longint t);
        while (ncyc < t) @(negedge clk);
    endtask

    task automatic raise_pps();
        pps_in = 1'b1;
        repeat (4) @(negedge clk);
        pps_in = 1'b0;
    endtask

    task automatic send(logic [1:0] kind, logic [31:0] data);
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = kind; msg_data = data;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 latched", latched_ticks, 0);
        chk("R1 tps", ticks_per_sec, 0);
        chk("R1 flags", {tps_valid, period_err, corr_valid, missed_pulse}, 0);
        chk("R1 paired", paired_time, 0);
        chk("R1 orphans", orphan_count, 0);
        rst_n = 1'b1;

        wait_until(10);  raise_pps();
        wait_until(100); send(2'd1, 32'h1111);
        chk("R5 paired in window", paired_time, 32'h1111);
        chk("R5 corr_valid set", corr_valid, 1);
        wait_until(120); send(2'd0, 32'h2222); send(2'd2, 32'h3333);
        chk("R8 paired unchanged", paired_time, 32'h1111);
        chk("R8 orphans unchanged", orphan_count, 0);
        chk("R8 corr_valid unchanged", corr_valid, 1);

        wait_until(1010); raise_pps();
        wait_until(1020);
        chk("R3 interval nominal", ticks_per_sec, 1000);
        chk("R3 tps_valid", tps_valid, 1);
        chk("R4 in tolerance", period_err, 0);
        chk("R6 cleared by pulse", corr_valid, 0);
        wait_until(1610); send(2'd1, 32'h4444);
        chk("R7 late message orphan", orphan_count, 1);
        chk("R7 paired kept", paired_time, 32'h1111);

        wait_until(2020); raise_pps();
        wait_until(2030);
        chk("R4 deviation 10 ok", period_err, 0);
        wait_until(2100); send(2'd1, 32'h5555);
        chk("R5 second pairing", paired_time, 32'h5555);
        wait_until(2150); send(2'd1, 32'h6666);
        chk("R10 extra message orphan", orphan_count, 2);
        chk("R10 paired kept", paired_time, 32'h5555);

        wait_until(3070); raise_pps();
        wait_until(3080);
        chk("R4 deviation 50 flagged", period_err, 1);
        wait_until(3100); send(2'd1, 32'h7777);
        chk("R6 paired despite error", paired_time, 32'h7777);
        chk("R6 corr invalid on error", corr_valid, 0);

        wait_until(4070);
        pps_in = 1'b1;
        @(negedge clk); @(negedge clk);
        msg_valid = 1'b1; msg_kind = 2'd1; msg_data = 32'h8888;
        @(negedge clk);
        msg_valid = 1'b0;
        chk("R11 same-edge orphan", orphan_count, 3);
        chk("R11 paired kept", paired_time, 32'h7777);
        repeat (2) @(negedge clk);
        pps_in = 1'b0;

        wait_until(5470);
        chk("R9 not yet missed", missed_pulse, 0);
        wait_until(5700);
        chk("R9 missed set", missed_pulse, 1);
        wait_until(6000); raise_pps();
        wait_until(6010);
        chk("R9 counter ran through gap", ticks_per_sec, 1930);
        chk("R9 still sticky", missed_pulse, 1);
        repeat (5) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule